// File: doc/BRIEF.md
# Real/Complex Decimating Down-Converter

This block takes a stream of signed real samples from a converter and reduces their rate by eight. In complex mode each sample is multiplied by a cosine and a negated sine from a numerically controlled oscillator. This moves the band of interest to DC. The resulting I and Q streams then pass through a low-pass filter and are decimated. In real mode the oscillator is not used. Only the real path is filtered and decimated, and the Q output stays at zero.

Complex mixing costs about 6 dB of amplitude, and the real path costs about 3 dB. A single gain-enable input recovers the loss that belongs to the selected mode. In complex mode it doubles I and Q. In real mode it multiplies by a fixed-point approximation of the square root of two. Every gained result is clamped to the signed output range. Mode, frequency word and gain enable are run-time inputs, normally driven by a configuration register file. A synchronous reset makes the output phase repeatable.

Top module: `dual_mode_ddc`

## Requirements
- R1: When `cfgComplex` is 1, the mixed values are I = floor(x·c / 2^15) and Q = floor(−x·s / 2^15). The NCO phase is a 16-bit accumulator that starts at 0 after reset and grows by `cfgFreqWord` once per accepted sample, using the phase value from before that step. Bits [15:14] of the phase select a quadrant. At quarter-turn phases (bits [13:0] zero), the (c, s) pairs for quadrants 0, 1, 2 and 3 are (32767, 0), (0, 32767), (−32767, 0) and (0, −32767).
- R2: `outValid` is a one-cycle pulse. It rises exactly one clock after the cycle that accepts every eighth sample since reset, and at no other time.
- R3: Each output is floor(S / 16), where S is the sum of the 16 most recent mixed values on that path. Positions not yet filled since reset count as zero. With the gain bit at 0 no further scaling is applied.
- R4: When `cfgComplex` is 1 and `cfgGainEn` is 1, both the I and Q filter results are multiplied by 2 before clamping.
- R5: When `cfgComplex` is 0, the input sample goes to the filter unmixed and `outQ` is 0 on every output.
- R6: When `cfgComplex` is 0 and `cfgGainEn` is 1, the I filter result r becomes floor(r·23170 / 16384) before clamping.
- R7: Gained results outside [−32768, 32767] are clamped to the nearest limit and never wrap.
- R8: While `rst` is 1 (sampled on the clock), the outputs are 0 and `outValid` is 0. Reset also clears the NCO phase, the filter history and the decimation count, so the same stream after reset always gives the same outputs.
- R9: A cycle with `inValid` at 0 does not advance the phase, the filter history or the decimation count. Gaps in the input therefore do not change the output values or their number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgComplex | input | 1 | 1 = complex mixing mode, 0 = real mode |
| cfgGainEn | input | 1 | Enables the loss-compensating gain for the selected mode |
| cfgFreqWord | input | 16 | NCO phase increment per accepted sample |
| inValid | input | 1 | Input sample strobe |
| inData | input | 16 | Signed input sample |
| outValid | output | 1 | One-cycle strobe per decimated output |
| outI | output | 16 | Signed I (or real) output |
| outQ | output | 16 | Signed Q output, 0 in real mode |

## Verification
Two effects are hard to observe from the ports: the sign convention of the quadrature product, and the floor rounding after mixing. With smooth input they average away in the filter. The bench uses frequency words that are multiples of a quarter turn, so every table value it meets is exact. A constant input then leaves a known residue of one LSB in both I and Q, and that residue shows the sign of each product. The clamp is reached by driving near-full-scale constants with gain enabled, in both directions and in both modes. Input gaps and a reset in the middle of a decimation period show that idle cycles and reset leave the output phase where it should be.

// File: rtl/dcv_pkg.sv
`timescale 1ns/1ps
package dcv_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic shift;  // accept a sample: advance NCO, shift history
    logic eval;   // evaluate filter and load outputs
  } dcvStrobeT;
endpackage

// File: rtl/dcv_nco.sv
`timescale 1ns/1ps
module dcv_nco #(
  parameter int PHASE_W  = 16,
  parameter int LUT_ADDR = 4,
  parameter int LUT_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    advance,
  input  logic [PHASE_W-1:0]      freqWord,
  output logic signed [LUT_W-1:0] cosVal,
  output logic signed [LUT_W-1:0] sinVal
);
  localparam int QPTS  = 1 << LUT_ADDR;
  localparam int ANG_W = LUT_ADDR + 2;
  localparam int AMP   = (1 << (LUT_W - 1)) - 1;
  localparam logic [ANG_W-1:0]  QTR_STEP = ANG_W'(QPTS);
  localparam logic [LUT_ADDR:0] QPTS_L   = (LUT_ADDR + 1)'(QPTS);

  // Rational sine approximation, exact at 0 and a quarter turn
  function automatic logic signed [LUT_W-1:0] sinApprox(input int k);
    longint d, num, den;
    d   = longint'(2 * QPTS);
    num = 16 * longint'(k) * (d - longint'(k));
    den = 5 * d * d - 4 * longint'(k) * (d - longint'(k));
    return LUT_W'((longint'(AMP) * num) / den);
  endfunction

  logic [PHASE_W-1:0]      phase;
  logic [ANG_W-1:0]        angS;
  logic signed [LUT_W-1:0] quarterTab [QPTS+1];
  logic [ANG_W-1:0]        ang [2];
  logic [LUT_ADDR:0]       idx [2];
  logic signed [LUT_W-1:0] mag [2];
  logic signed [LUT_W-1:0] val [2];

  always_ff @(posedge clk) begin
    if (rst)          phase <= '0;
    else if (advance) phase <= phase + freqWord;
  end

  assign angS = phase[PHASE_W-1 -: ANG_W];

  for (genvar k = 0; k <= QPTS; k++) begin : g_tab
    assign quarterTab[k] = sinApprox(k);
  end

  // w = 0 gives sine, w = 1 gives cosine (angle advanced a quarter turn)
  for (genvar w = 0; w < 2; w++) begin : g_look
    assign ang[w] = angS + ((w == 1) ? QTR_STEP : '0);
    assign idx[w] = ang[w][LUT_ADDR] ? (QPTS_L - {1'b0, ang[w][LUT_ADDR-1:0]})
                                     : {1'b0, ang[w][LUT_ADDR-1:0]};
    assign mag[w] = quarterTab[idx[w]];
    assign val[w] = ang[w][ANG_W-1] ? -mag[w] : mag[w];
  end

  assign sinVal = val[0];
  assign cosVal = val[1];

  // R1: phase steps by the frequency word on each accepted sample
  a_r1_phase_step: assert property (@(posedge clk) disable iff (rst)
    ($past(advance) && !$past(rst)) |-> (phase == $past(phase) + $past(freqWord)));

  // R1: on a quadrant boundary exactly one of sine/cosine is zero
  a_r1_quadrant_exact: assert property (@(posedge clk) disable iff (rst)
    (angS[LUT_ADDR-1:0] == '0) |-> ((sinVal == '0) != (cosVal == '0)));
endmodule

// File: rtl/dcv_ctrl.sv
`timescale 1ns/1ps
module dcv_ctrl
  import dcv_pkg::*;
#(
  parameter int DECIM = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      inValid,
  output dcvStrobeT strb
);
  localparam int CNT_W = $clog2(DECIM);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DECIM - 1);

  logic [CNT_W-1:0] count;
  logic             evalQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      evalQ <= 1'b0;
    end else begin
      evalQ <= 1'b0;
      if (inValid) begin
        if (count == LAST_SLOT) begin
          count <= '0;
          evalQ <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strb.shift = inValid;
    strb.eval  = evalQ;
  end

  // R2: evaluation strobe is a single-cycle pulse
  a_r2_eval_single: assert property (@(posedge clk) disable iff (rst)
    evalQ |=> !evalQ);

  // R2: evaluation only follows an accepted sample
  a_r2_eval_after_input: assert property (@(posedge clk) disable iff (rst)
    evalQ |-> $past(inValid));

  // R9: idle cycles leave the decimation count alone
  a_r9_idle_holds_count: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(count));
endmodule

// File: rtl/dcv_datapath.sv
`timescale 1ns/1ps
module dcv_datapath
  import dcv_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 16,
  parameter int PHASE_W  = 16,
  parameter int LUT_ADDR = 4,
  parameter int LUT_W    = 16,
  parameter int TAPS     = 16,
  parameter int ROOT2_NUM = 23170,
  parameter int ROOT2_SH  = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dcvStrobeT               strb,
  input  logic                    cfgComplex,
  input  logic                    cfgGainEn,
  input  logic [PHASE_W-1:0]      freqWord,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outI,
  output logic signed [OUT_W-1:0] outQ
);
  localparam int LOG_T  = $clog2(TAPS);
  localparam int SUM_W  = IN_W + LOG_T;
  localparam int PROD_W = IN_W + LUT_W;
  localparam int GW     = IN_W + ROOT2_SH + 3;
  localparam logic signed [GW-1:0] ROOT2_K = GW'(ROOT2_NUM);
  localparam logic signed [GW-1:0] SAT_HI  = GW'((longint'(1) << (OUT_W - 1)) - 1);
  localparam logic signed [GW-1:0] SAT_LO  = ~SAT_HI;

  logic signed [LUT_W-1:0]  cosVal, sinVal;
  logic signed [PROD_W-1:0] prodI, prodQ;
  logic signed [IN_W-1:0]   mix [2];
  logic [2*OUT_W-1:0]       outBus;

  dcv_nco #(
    .PHASE_W (PHASE_W),
    .LUT_ADDR(LUT_ADDR),
    .LUT_W   (LUT_W)
  ) nco_i (
    .clk     (clk),
    .rst     (rst),
    .advance (strb.shift),
    .freqWord(freqWord),
    .cosVal  (cosVal),
    .sinVal  (sinVal)
  );

  // Down-conversion: multiply by cosine and negated sine
  assign prodI = PROD_W'(inData) * PROD_W'(cosVal);
  assign prodQ = -(PROD_W'(inData) * PROD_W'(sinVal));

  always_comb begin
    if (cfgComplex) begin
      mix[0] = prodI[LUT_W-1 +: IN_W];
      mix[1] = prodQ[LUT_W-1 +: IN_W];
    end else begin
      mix[0] = inData;
      mix[1] = '0;
    end
  end

  // One lane per path: history, folded boxcar FIR, gain, clamp, output register
  for (genvar p = 0; p < 2; p++) begin : g_lane
    logic signed [IN_W-1:0]  dly [TAPS];
    logic signed [SUM_W-1:0] acc;
    logic signed [IN_W-1:0]  avg;
    logic signed [GW-1:0]    ext, scaled, boosted;
    logic signed [OUT_W-1:0] sat, laneNext, laneReg;

    always_ff @(posedge clk) begin
      if (rst) begin
        for (int k = 0; k < TAPS; k++) dly[k] <= '0;
      end else if (strb.shift) begin
        dly[0] <= mix[p];
        for (int k = 1; k < TAPS; k++) dly[k] <= dly[k-1];
      end
    end

    // Symmetric taps are pre-added in pairs before the sum
    always_comb begin
      acc = '0;
      for (int k = 0; k < TAPS / 2; k++)
        acc = acc + SUM_W'(dly[k]) + SUM_W'(dly[TAPS-1-k]);
    end

    assign avg    = acc[SUM_W-1:LOG_T];
    assign ext    = GW'(avg);
    assign scaled = ext * ROOT2_K;

    always_comb begin
      if (cfgGainEn && cfgComplex) boosted = ext + ext;
      else if (cfgGainEn)          boosted = scaled >>> ROOT2_SH;
      else                         boosted = ext;
    end

    always_comb begin
      if (boosted > SAT_HI)      sat = SAT_HI[OUT_W-1:0];
      else if (boosted < SAT_LO) sat = SAT_LO[OUT_W-1:0];
      else                       sat = boosted[OUT_W-1:0];
    end

    assign laneNext = ((p == 1) && !cfgComplex) ? '0 : sat;

    always_ff @(posedge clk) begin
      if (rst)            laneReg <= '0;
      else if (strb.eval) laneReg <= laneNext;
    end

    assign outBus[p*OUT_W +: OUT_W] = laneReg;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= strb.eval;
  end

  assign outI = outBus[OUT_W-1:0];
  assign outQ = outBus[2*OUT_W-1:OUT_W];

  // R2: output strobe never lasts two cycles
  a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    outValid |=> !outValid);

  // R8: no output in the first cycle after reset
  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  // R5: real mode leaves Q at zero
  a_r5_real_q_zero: assert property (@(posedge clk) disable iff (rst)
    (outValid && !$past(cfgComplex)) |-> (outQ == '0));

  // R4: doubled, unclamped I results are even
  a_r4_double_even: assert property (@(posedge clk) disable iff (rst)
    (outValid && $past(cfgComplex && cfgGainEn) && (outI != SAT_HI[OUT_W-1:0]))
      |-> !outI[0]);
endmodule

// File: rtl/dual_mode_ddc.sv
`timescale 1ns/1ps
module dual_mode_ddc
  import dcv_pkg::*;
#(
  parameter int IN_W     = 16,
  parameter int OUT_W    = 16,
  parameter int PHASE_W  = 16,
  parameter int LUT_ADDR = 4,
  parameter int LUT_W    = 16,
  parameter int TAPS     = 16,
  parameter int DECIM    = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfgComplex,
  input  logic                    cfgGainEn,
  input  logic [PHASE_W-1:0]      cfgFreqWord,
  input  logic                    inValid,
  input  logic signed [IN_W-1:0]  inData,
  output logic                    outValid,
  output logic signed [OUT_W-1:0] outI,
  output logic signed [OUT_W-1:0] outQ
);
  dcvStrobeT strb;

  dcv_ctrl #(.DECIM(DECIM)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .inValid(inValid),
    .strb   (strb)
  );

  dcv_datapath #(
    .IN_W    (IN_W),
    .OUT_W   (OUT_W),
    .PHASE_W (PHASE_W),
    .LUT_ADDR(LUT_ADDR),
    .LUT_W   (LUT_W),
    .TAPS    (TAPS)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cfgComplex(cfgComplex),
    .cfgGainEn (cfgGainEn),
    .freqWord  (cfgFreqWord),
    .inData    (inData),
    .outValid  (outValid),
    .outI      (outI),
    .outQ      (outQ)
  );
endmodule

// File: tb/dual_mode_ddc_tb.sv
`timescale 1ns/1ps
module dual_mode_ddc_tb_top;
  logic               clk = 1'b0;
  logic               rst;
  logic               cfgComplex, cfgGainEn;
  logic [15:0]        cfgFreqWord;
  logic               inValid;
  logic signed [15:0] inData;
  logic               outValid;
  logic signed [15:0] outI, outQ;

  always #2 clk = ~clk;

  dual_mode_ddc dut_i (
    .clk(clk), .rst(rst), .cfgComplex(cfgComplex), .cfgGainEn(cfgGainEn),
    .cfgFreqWord(cfgFreqWord), .inValid(inValid), .inData(inData),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int    nChecks = 0, nErr = 0;
  string curTag = "R3";
  int    outSeen = 0, lastI = 0, lastQ = 0;
  int    hI [16], hQ [16];
  int    refPhase = 0, accepted = 0;
  bit    pend = 0;
  int    expI = 0, expQ = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int clampOut(input int v);
    if (v > 32767)  return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic int refGain(input int avg, input bit cplx, input bit gain);
    if (gain && cplx) return clampOut(avg * 2);
    if (gain)         return clampOut(int'((longint'(avg) * 23170) >>> 14));
    return clampOut(avg);
  endfunction

  // Reference mixing, valid for phases on quarter turns
  task automatic refMix(input int x, input int ph, input bit cplx, output int mi, output int mq);
    longint c, s;
    if (!cplx) begin
      mi = x; mq = 0;
    end else begin
      case ((ph >> 14) & 3)
        0:       begin c = 32767;  s = 0;      end
        1:       begin c = 0;      s = 32767;  end
        2:       begin c = -32767; s = 0;      end
        default: begin c = 0;      s = -32767; end
      endcase
      mi = int'((longint'(x) * c) >>> 15);
      mq = int'((-(longint'(x) * s)) >>> 15);
    end
  endtask

  // Reference model and output monitor
  always @(posedge clk) begin : monitor
    bit expNow;
    int eI, eQ, mi, mq, sI, sQ;
    expNow = pend; eI = expI; eQ = expQ; pend = 0;
    if (rst) begin
      for (int k = 0; k < 16; k++) begin hI[k] = 0; hQ[k] = 0; end
      refPhase = 0; accepted = 0; expNow = 0;
    end else if (inValid) begin
      refMix(int'(inData), refPhase, cfgComplex, mi, mq);
      for (int k = 15; k > 0; k--) begin hI[k] = hI[k-1]; hQ[k] = hQ[k-1]; end
      hI[0] = mi; hQ[0] = mq;
      refPhase = (refPhase + int'(cfgFreqWord)) & 16'hFFFF;
      accepted++;
      if (accepted % 8 == 0) begin
        sI = 0; sQ = 0;
        for (int k = 0; k < 16; k++) begin sI += hI[k]; sQ += hQ[k]; end
        expI = refGain(sI >>> 4, cfgComplex, cfgGainEn);
        expQ = cfgComplex ? refGain(sQ >>> 4, 1'b1, cfgGainEn) : 0;
        pend = 1;
      end
    end
    #1;
    if (!rst && (expNow || outValid)) begin
      check("R2", "output strobe timing", int'(outValid), int'(expNow));
      if (outValid && expNow) begin
        check(curTag, "I output vs model", int'(outI), eI);
        check(curTag, "Q output vs model", int'(outQ), eQ);
        outSeen++; lastI = int'(outI); lastQ = int'(outQ);
      end
    end
  end

  task automatic doReset();
    @(negedge clk); rst = 1'b1; inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic feed(input int x);
    @(negedge clk); inValid = 1'b1; inData = 16'(x);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); inValid = 1'b0; end
  endtask

  task automatic setCfg(input bit cplx, input bit gain, input int freq);
    cfgComplex = cplx; cfgGainEn = gain; cfgFreqWord = 16'(freq);
  endtask

  task automatic t_reset();
    curTag = "R8";
    rst = 1'b1; inValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R8", "outValid in reset", int'(outValid), 0);
    check("R8", "outI in reset", int'(outI), 0);
    check("R8", "outQ in reset", int'(outQ), 0);
    rst = 1'b0;
  endtask

  task automatic t_complexDc();
    int base;
    curTag = "R3"; setCfg(1, 0, 0); doReset(); base = outSeen;
    repeat (24) feed(1000);
    idle(4);
    check("R2", "outputs for 24 samples", outSeen - base, 3);
    check("R3", "settled DC I", lastI, 999);
    check("R3", "settled DC Q", lastQ, 0);
  endtask

  task automatic t_complexRotate();
    int base;
    curTag = "R1"; setCfg(1, 0, 16'h4000); doReset();
    repeat (16) feed(4000);
    idle(4);
    check("R1", "quarter-rate I residue", lastI, -1);
    check("R1", "quarter-rate Q residue", lastQ, -1);
    doReset(); base = outSeen;
    for (int k = 0; k < 32; k++) feed(100 * k - 1500);
    idle(4);
    check("R1", "ramp outputs", outSeen - base, 4);
    setCfg(1, 0, 16'h8000); doReset();
    repeat (16) feed(-2000);
    idle(4);
    check("R1", "half-rate I residue", lastI, -1);
    check("R1", "half-rate Q", lastQ, 0);
  endtask

  task automatic t_complexGain();
    curTag = "R4"; setCfg(1, 1, 0); doReset();
    repeat (16) feed(5000);
    idle(4);
    check("R4", "doubled I", lastI, 9998);
    setCfg(1, 1, 16'hC000); doReset();
    for (int k = 0; k < 24; k++) feed(700 * k - 9000);
    idle(4);
    curTag = "R7"; setCfg(1, 1, 0); doReset();
    repeat (16) feed(30000);
    idle(4);
    check("R7", "complex clamp high", lastI, 32767);
    doReset();
    repeat (16) feed(-30000);
    idle(4);
    check("R7", "complex clamp low", lastI, -32768);
  endtask

  task automatic t_realMode();
    curTag = "R5"; setCfg(0, 0, 16'h4000); doReset();
    repeat (16) feed(4000);
    idle(4);
    check("R5", "real I unmixed", lastI, 4000);
    check("R5", "real Q zero", lastQ, 0);
    doReset();
    for (int k = 0; k < 24; k++) feed(321 * k - 3000);
    idle(4);
  endtask

  task automatic t_realGain();
    curTag = "R6"; setCfg(0, 1, 0); doReset();
    repeat (16) feed(10000);
    idle(4);
    check("R6", "root-two gain", lastI, 14141);
    check("R6", "Q stays zero", lastQ, 0);
    curTag = "R7"; doReset();
    repeat (16) feed(32767);
    idle(4);
    check("R7", "real clamp high", lastI, 32767);
    doReset();
    repeat (16) feed(-32768);
    idle(4);
    check("R7", "real clamp low", lastI, -32768);
  endtask

  task automatic t_gaps();
    int base;
    curTag = "R9"; setCfg(1, 0, 16'h4000); doReset(); base = outSeen;
    for (int k = 0; k < 24; k++) begin
      feed(250 * k - 2500);
      idle(k % 3);
    end
    idle(4);
    check("R9", "outputs with gaps", outSeen - base, 3);
    base = outSeen;
    idle(20);
    check("R9", "no output while idle", outSeen - base, 0);
  endtask

  task automatic t_midReset();
    int base;
    curTag = "R8"; setCfg(0, 0, 0); doReset();
    repeat (5) feed(9999);
    doReset(); base = outSeen;
    repeat (8) feed(1600);
    idle(4);
    check("R8", "one output after reset", outSeen - base, 1);
    check("R8", "history cleared", lastI, 800);
    setCfg(1, 0, 16'h4000); doReset();
    repeat (3) feed(7000);
    doReset();
    repeat (16) feed(4000);
    idle(4);
    check("R8", "phase cleared I", lastI, -1);
    check("R8", "phase cleared Q", lastQ, -1);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog R2: actual 50000 cycles expected completion earlier");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin : main
    rst = 1'b1; inValid = 1'b0; inData = '0;
    setCfg(1, 0, 0);
    t_reset();
    t_complexDc();
    t_complexRotate();
    t_complexGain();
    t_realMode();
    t_realGain();
    t_gaps();
    t_midReset();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule